// File: doc/BRIEF.md
# Gather-Capable Transmit Descriptor Ring Engine

This engine walks a circular ring of transmit descriptors that host software fills. Each descriptor names a buffer with a 40-bit address, a byte count, a metadata word, a byte-swap flag and a gather flag. Software stores descriptors in ring memory and then posts a new write index. The engine reads descriptors from its own read position up to that index and requests each buffer over a simple request/response read port. It forwards the returned 32-bit words on an output stream and byte-reverses them when the descriptor asks for it.

A descriptor with its gather flag set continues the current outgoing transfer. The transfer closes at the next descriptor whose gather flag is clear. The engine emits no part of a chain until the closing descriptor has been posted. A closed chain leaves as one stream transfer, followed by one completion event that carries the closing descriptor's fields. The completion event also moves a completed index past the whole chain. Software reaps completed entries one at a time. The engine reports how many completed entries are still unreaped, and flags the ring as full when one more posted entry would reach the reap position.

Top module: `src_ring_engine`

## Requirements
- R1: While reset is asserted, and directly after it, the hardware read index and the unreaped count are zero, the ring is not full, and no buffer request, output word or completion is active.
- R2: Every ring index has log2(RING_DEPTH) bits and wraps from RING_DEPTH-1 to 0, so RING_DEPTH must be a power of two.
- R3: `ring_full` is high exactly when the posted write index plus one, modulo RING_DEPTH, equals the reap position. At most RING_DEPTH-1 entries can therefore be outstanding.
- R4: A buffer request carries the address {high byte, low word} and the byte count of its descriptor. Address and count stay stable while the request waits for `mem_req_ready`.
- R5: When a descriptor's swap flag is 1, every output word is byte-reversed (output bits 7:0 equal input bits 31:24, and so on). When the flag is 0, words pass unchanged.
- R6: `out_last` is high only on the final word of a chain's closing descriptor, that is, the first descriptor with its gather flag at 0.
- R7: Each chain raises exactly one `cmpl_valid` pulse, after its last output word. The pulse carries the closing descriptor's address, byte count and metadata. The completed index then points one past the closing descriptor.
- R8: While a chain is still open at the posted write index, the engine issues no buffer request and does not advance its read index.
- R9: `done_cnt` equals completed minus reaped entries. A reap pulse while `done_cnt` is zero has no effect.
- R10: The hardware read index advances by exactly one per consumed descriptor and stops at the posted write index.
- R11: A descriptor with a byte count of zero issues no buffer request and emits no word, but it is still consumed and counted within its chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| host_wr_we | input | 1 | Host posts a new write index |
| host_wr_idx | input | IDX_W | Posted write index |
| host_reap | input | 1 | Host reaps one completed entry |
| desc_rd_en | output | 1 | Descriptor memory read strobe |
| desc_rd_idx | output | IDX_W | Descriptor memory read index |
| dsc_addr_lo | input | 32 | Read descriptor, address low word (one cycle after strobe) |
| dsc_addr_hi | input | 8 | Read descriptor, address high byte |
| dsc_nbytes | input | LEN_W | Read descriptor, byte count |
| dsc_meta | input | META_W | Read descriptor, metadata |
| dsc_swap | input | 1 | Read descriptor, byte-swap flag |
| dsc_gather | input | 1 | Read descriptor, gather flag |
| mem_req_valid | output | 1 | Buffer read request valid |
| mem_req_ready | input | 1 | Buffer read request accepted |
| mem_req_addr | output | 40 | Buffer address |
| mem_req_len | output | LEN_W | Buffer byte count |
| mem_rvalid | input | 1 | Buffer read data valid |
| mem_rdata | input | DATA_W | Buffer read data word |
| out_valid | output | 1 | Output word valid |
| out_data | output | DATA_W | Output word, optionally byte-reversed |
| out_last | output | 1 | Final word of a transfer |
| cmpl_valid | output | 1 | Chain completion pulse |
| cmpl_addr | output | 40 | Completed descriptor address |
| cmpl_len | output | LEN_W | Completed descriptor byte count |
| cmpl_meta | output | META_W | Completed descriptor metadata |
| hw_rd_idx | output | IDX_W | Hardware read index |
| done_cnt | output | IDX_W | Completed but unreaped entries |
| ring_full | output | 1 | Ring full flag |

## Verification
A chain completion and a host reap can occur in the same cycle. In that cycle the unreaped count must rise by the chain length and fall by one together. The bench holds the reap input high for the whole of a multi-chain run, so reaps fall on completion cycles and also on cycles where the count is still zero. A behavioural model updates the expected count from both events and compares it with `done_cnt` and `ring_full` on every clock. A second pair of events is a write-index post that lands while an open chain is stalled. The bench checks that nothing moves until that post arrives.

// File: rtl/src_ring_pkg.sv
package src_ring_pkg;
  localparam int ADDR_LO_W = 32;
  localparam int ADDR_HI_W = 8;
  localparam int BUF_ADDR_W = ADDR_LO_W + ADDR_HI_W;

  typedef enum logic [2:0] {
    ST_SCAN,
    ST_SCAN_W,
    ST_FETCH,
    ST_LOAD,
    ST_REQ,
    ST_DATA,
    ST_DONE
  } eng_state_e;
endpackage

// File: rtl/ring_ptrs.sv
module ring_ptrs #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_we,
  input  logic [IDX_W-1:0] post_idx,
  input  logic             cmpl_we,
  input  logic [IDX_W-1:0] cmpl_nxt,
  input  logic             reap_req,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] cmpl_idx,
  output logic [IDX_W-1:0] pend_cnt,
  output logic             full
);
  logic [IDX_W-1:0] reap_q, reap_d, wr_d, cmpl_d;
  logic             reap_ok;

  always_comb begin
    pend_cnt = cmpl_idx - reap_q;
    reap_ok  = reap_req && (pend_cnt != '0);
    reap_d   = reap_ok ? reap_q + 1'b1 : reap_q;
    wr_d     = post_we ? post_idx : wr_idx;
    cmpl_d   = cmpl_we ? cmpl_nxt : cmpl_idx;
    full     = (IDX_W'(wr_idx + 1'b1) == reap_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx   <= '0;
      cmpl_idx <= '0;
      reap_q   <= '0;
    end else begin
      if (post_we) wr_idx <= wr_d;
      if (cmpl_we) cmpl_idx <= cmpl_d;
      if (reap_ok) reap_q <= reap_d;
    end
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             beat,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (beat && cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
    last   = (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lane_swap.sv
module lane_swap #(
  parameter int BYTES = 4
) (
  input  logic               en,
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign dout[8*b +: 8] = en ? din[8*(BYTES-1-b) +: 8] : din[8*b +: 8];
  end
endmodule

// File: rtl/src_ring_engine.sv
module src_ring_engine
  import src_ring_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int LEN_W      = 16,
  parameter int META_W     = 16,
  parameter int DATA_W     = 32,
  localparam int IDX_W     = $clog2(RING_DEPTH),
  localparam int WB        = DATA_W / 8,
  localparam int WB_SH     = $clog2(WB)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr_we,
  input  logic [IDX_W-1:0]      host_wr_idx,
  input  logic                  host_reap,
  output logic                  desc_rd_en,
  output logic [IDX_W-1:0]      desc_rd_idx,
  input  logic [ADDR_LO_W-1:0]  dsc_addr_lo,
  input  logic [ADDR_HI_W-1:0]  dsc_addr_hi,
  input  logic [LEN_W-1:0]      dsc_nbytes,
  input  logic [META_W-1:0]     dsc_meta,
  input  logic                  dsc_swap,
  input  logic                  dsc_gather,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [BUF_ADDR_W-1:0] mem_req_addr,
  output logic [LEN_W-1:0]      mem_req_len,
  input  logic                  mem_rvalid,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     out_data,
  output logic                  out_last,
  output logic                  cmpl_valid,
  output logic [BUF_ADDR_W-1:0] cmpl_addr,
  output logic [LEN_W-1:0]      cmpl_len,
  output logic [META_W-1:0]     cmpl_meta,
  output logic [IDX_W-1:0]      hw_rd_idx,
  output logic [IDX_W-1:0]      done_cnt,
  output logic                  ring_full
);
  eng_state_e st_q, st_d;
  logic [IDX_W-1:0]      scan_q, scan_d, cur_q, cur_d;
  logic [BUF_ADDR_W-1:0] d_addr_q;
  logic [LEN_W-1:0]      d_len_q;
  logic [META_W-1:0]     d_meta_q;
  logic                  d_swap_q, d_gather_q;
  logic                  ld_desc, cmpl_we, beat, last_beat;
  logic [IDX_W-1:0]      wr_idx, cmpl_idx;
  logic [LEN_W:0]        wc_sum;
  logic [LEN_W-1:0]      word_cnt;

  assign wc_sum   = {1'b0, dsc_nbytes} + (LEN_W+1)'(WB - 1);
  assign word_cnt = LEN_W'(wc_sum >> WB_SH);

  ring_ptrs #(.IDX_W(IDX_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .post_we(host_wr_we), .post_idx(host_wr_idx),
    .cmpl_we(cmpl_we), .cmpl_nxt(cur_d),
    .reap_req(host_reap),
    .wr_idx(wr_idx), .cmpl_idx(cmpl_idx),
    .pend_cnt(done_cnt), .full(ring_full)
  );

  beat_counter #(.CNT_W(LEN_W)) u_beats (
    .clk(clk), .rst_n(rst_n),
    .load(ld_desc), .load_val(word_cnt),
    .beat(beat), .last(last_beat)
  );

  lane_swap #(.BYTES(WB)) u_swap (
    .en(d_swap_q), .din(mem_rdata), .dout(out_data)
  );

  // next-state: scan to a closing descriptor, then replay the chain
  always_comb begin
    st_d        = st_q;
    scan_d      = scan_q;
    cur_d       = cur_q;
    desc_rd_en  = 1'b0;
    desc_rd_idx = cur_q;
    ld_desc     = 1'b0;
    cmpl_we     = 1'b0;
    unique case (st_q)
      ST_SCAN: begin
        if (scan_q != wr_idx) begin
          desc_rd_en  = 1'b1;
          desc_rd_idx = scan_q;
          st_d        = ST_SCAN_W;
        end
      end
      ST_SCAN_W: begin
        scan_d = scan_q + 1'b1;
        st_d   = dsc_gather ? ST_SCAN : ST_FETCH;
      end
      ST_FETCH: begin
        desc_rd_en = 1'b1;
        st_d       = ST_LOAD;
      end
      ST_LOAD: begin
        ld_desc = 1'b1;
        st_d    = (dsc_nbytes == '0) ? ST_DONE : ST_REQ;
      end
      ST_REQ:  if (mem_req_ready) st_d = ST_DATA;
      ST_DATA: if (mem_rvalid && last_beat) st_d = ST_DONE;
      ST_DONE: begin
        cur_d   = cur_q + 1'b1;
        cmpl_we = !d_gather_q;
        st_d    = (cur_d == scan_q) ? ST_SCAN : ST_FETCH;
      end
      default: st_d = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_SCAN;
      scan_q     <= '0;
      cur_q      <= '0;
      d_addr_q   <= '0;
      d_len_q    <= '0;
      d_meta_q   <= '0;
      d_swap_q   <= 1'b0;
      d_gather_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      scan_q <= scan_d;
      cur_q  <= cur_d;
      if (ld_desc) begin
        d_addr_q   <= {dsc_addr_hi, dsc_addr_lo};
        d_len_q    <= dsc_nbytes;
        d_meta_q   <= dsc_meta;
        d_swap_q   <= dsc_swap;
        d_gather_q <= dsc_gather;
      end
    end
  end

  assign beat          = (st_q == ST_DATA) && mem_rvalid;
  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_addr  = d_addr_q;
  assign mem_req_len   = d_len_q;
  assign out_valid     = beat;
  assign out_last      = beat && last_beat && !d_gather_q;
  assign cmpl_valid    = cmpl_we;
  assign cmpl_addr     = d_addr_q;
  assign cmpl_len      = d_len_q;
  assign cmpl_meta     = d_meta_q;
  assign hw_rd_idx     = cur_q;
endmodule

// File: rtl/src_ring_checker.sv
module src_ring_checker #(
  parameter int IDX_W = 3,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] hw_rd_idx,
  input logic [IDX_W-1:0] cmpl_idx,
  input logic             cmpl_valid,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [39:0]      mem_req_addr,
  input logic [LEN_W-1:0] mem_req_len,
  input logic             out_last,
  input logic             host_reap,
  input logic [IDX_W-1:0] done_cnt
);
  a_r10_rd_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rd_idx != $past(hw_rd_idx) |-> hw_rd_idx == IDX_W'($past(hw_rd_idx) + 1'b1));

  a_r7_cmpl_idx_jump: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |=> cmpl_idx == hw_rd_idx);

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len));

  a_r6_last_then_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> cmpl_valid);

  a_r9_reap_empty: assert property (@(posedge clk) disable iff (!rst_n)
    host_reap && done_cnt == '0 && !cmpl_valid |=> done_cnt == '0);
endmodule

bind src_ring_engine src_ring_checker #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_rd_idx(hw_rd_idx), .cmpl_idx(cmpl_idx),
  .cmpl_valid(cmpl_valid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_req_len(mem_req_len), .out_last(out_last), .host_reap(host_reap),
  .done_cnt(done_cnt)
);

// File: tb/src_ring_engine_bench.sv
module src_ring_engine_bench;
  localparam int DEPTH = 8;
  localparam int IW = 3;
  localparam int LW = 16;
  localparam int MW = 16;
  localparam logic [31:0] KSTEP = 32'h01030507;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic host_wr_we = 1'b0, host_reap = 1'b0;
  logic [IW-1:0] host_wr_idx = '0;
  logic desc_rd_en; logic [IW-1:0] desc_rd_idx;
  logic [31:0] dsc_addr_lo = '0; logic [7:0] dsc_addr_hi = '0;
  logic [LW-1:0] dsc_nbytes = '0; logic [MW-1:0] dsc_meta = '0;
  logic dsc_swap = 1'b0, dsc_gather = 1'b0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [39:0] mem_req_addr; logic [LW-1:0] mem_req_len;
  logic mem_rvalid = 1'b0; logic [31:0] mem_rdata = '0;
  logic out_valid, out_last; logic [31:0] out_data;
  logic cmpl_valid; logic [39:0] cmpl_addr; logic [LW-1:0] cmpl_len; logic [MW-1:0] cmpl_meta;
  logic [IW-1:0] hw_rd_idx, done_cnt; logic ring_full;

  src_ring_engine u_src_ring_engine (
    .clk(clk), .rst_n(rst_n), .host_wr_we(host_wr_we), .host_wr_idx(host_wr_idx),
    .host_reap(host_reap), .desc_rd_en(desc_rd_en), .desc_rd_idx(desc_rd_idx),
    .dsc_addr_lo(dsc_addr_lo), .dsc_addr_hi(dsc_addr_hi), .dsc_nbytes(dsc_nbytes),
    .dsc_meta(dsc_meta), .dsc_swap(dsc_swap), .dsc_gather(dsc_gather),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .cmpl_valid(cmpl_valid), .cmpl_addr(cmpl_addr), .cmpl_len(cmpl_len),
    .cmpl_meta(cmpl_meta), .hw_rd_idx(hw_rd_idx), .done_cnt(done_cnt),
    .ring_full(ring_full)
  );

  int n_chk = 0, n_bad = 0, n_req = 0;

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ring memory, one-cycle read latency
  logic [31:0] r_lo [DEPTH]; logic [7:0] r_hi [DEPTH]; logic [LW-1:0] r_len [DEPTH];
  logic [MW-1:0] r_meta [DEPTH]; logic r_swap [DEPTH]; logic r_gat [DEPTH];
  always @(posedge clk) if (desc_rd_en) begin
    dsc_addr_lo <= r_lo[desc_rd_idx]; dsc_addr_hi <= r_hi[desc_rd_idx];
    dsc_nbytes  <= r_len[desc_rd_idx]; dsc_meta   <= r_meta[desc_rd_idx];
    dsc_swap    <= r_swap[desc_rd_idx]; dsc_gather <= r_gat[desc_rd_idx];
  end

  // buffer memory model with irregular ready and data gaps
  int cyc = 0, m_left = 0, m_i = 0; logic [31:0] m_base = '0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 0;
    mem_rvalid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      m_left <= (int'(mem_req_len) + 3) / 4; m_base <= mem_req_addr[31:0]; m_i <= 0;
    end else if (m_left > 0 && (cyc % 4) != 3) begin
      mem_rvalid <= 1'b1; mem_rdata <= m_base + 32'(m_i) * KSTEP;
      m_i <= m_i + 1; m_left <= m_left - 1;
    end
  end

  // reference model
  logic [55:0] q_req[$]; logic [32:0] q_word[$]; logic [71:0] q_cmpl[$]; int q_clen[$];
  int m_pend = 0, open_len = 0;
  logic [IW-1:0] m_wr = '0, m_reap = '0, w_stage = '0;

  task automatic add_desc(input logic [31:0] lo, input logic [7:0] hi, input int len,
                          input logic [MW-1:0] meta, input bit sw, input bit gat);
    int n;
    logic [31:0] raw, d;
    r_lo[w_stage] = lo; r_hi[w_stage] = hi; r_len[w_stage] = LW'(len);
    r_meta[w_stage] = meta; r_swap[w_stage] = sw; r_gat[w_stage] = gat;
    n = (len + 3) / 4;
    if (len != 0) q_req.push_back({hi, lo, LW'(len)});
    for (int i = 0; i < n; i++) begin
      raw = lo + 32'(i) * KSTEP;
      d = sw ? {raw[7:0], raw[15:8], raw[23:16], raw[31:24]} : raw;
      q_word.push_back({(!gat && i == n - 1), d});
    end
    open_len++;
    if (!gat) begin
      q_cmpl.push_back({hi, lo, LW'(len), meta});
      q_clen.push_back(open_len);
      open_len = 0;
    end
    w_stage = w_stage + 1'b1;
  endtask

  task automatic post();
    @(posedge clk); #2 host_wr_we = 1'b1; host_wr_idx = w_stage;
    @(posedge clk); #2 host_wr_we = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (!(q_word.size() == 0 && q_cmpl.size() == 0 && hw_rd_idx == w_stage) && t < 3000) begin
      @(posedge clk); t++;
    end
    repeat (3) @(posedge clk);
    chk(t < 3000, "R10 idle reached", 80'(t), 80'(3000));
  endtask

  task automatic drain();
    #2 host_reap = 1'b1;
    while (m_pend != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #2 host_reap = 1'b0;
  endtask

  // per-clock comparison
  always @(negedge clk) if (rst_n) begin
    int add;
    bit eff;
    logic [55:0] er; logic [32:0] ew; logic [71:0] ec;
    add = 0;
    chk(done_cnt == IW'(m_pend), "R9 unreaped count", 80'(done_cnt), 80'(m_pend));
    chk(ring_full == (IW'(m_wr + 1'b1) == m_reap), "R3 full flag", 80'(ring_full),
        80'(IW'(m_wr + 1'b1) == m_reap));
    if (mem_req_valid && mem_req_ready) begin
      n_req++;
      er = (q_req.size() != 0) ? q_req.pop_front() : '1;
      chk({mem_req_addr, mem_req_len} == er, "R4 request fields",
          80'({mem_req_addr, mem_req_len}), 80'(er));
    end
    if (out_valid) begin
      ew = (q_word.size() != 0) ? q_word.pop_front() : '1;
      chk({out_last, out_data} == ew, "R5 R6 output word", 80'({out_last, out_data}), 80'(ew));
    end else begin
      chk(!out_last, "R6 last without word", 80'(out_last), 80'(0));
    end
    if (cmpl_valid) begin
      ec = (q_cmpl.size() != 0) ? q_cmpl.pop_front() : '1;
      add = (q_clen.size() != 0) ? q_clen.pop_front() : 0;
      chk({cmpl_addr, cmpl_len, cmpl_meta} == ec, "R7 completion fields",
          80'({cmpl_addr, cmpl_len, cmpl_meta}), 80'(ec));
    end
    eff = host_reap && (m_pend > 0);
    if (eff) m_reap = m_reap + 1'b1;
    m_pend = m_pend + add - int'(eff);
    if (host_wr_we) m_wr = host_wr_idx;
  end

  initial begin
    int req0; logic [IW-1:0] rd0; int wq0;
    repeat (3) @(negedge clk);
    chk(hw_rd_idx == 0 && done_cnt == 0, "R1 reset indices", 80'({hw_rd_idx, done_cnt}), 80'(0));
    chk(!ring_full && !mem_req_valid && !out_valid && !cmpl_valid, "R1 reset idle",
        80'({ring_full, mem_req_valid, out_valid, cmpl_valid}), 80'(0));
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk(hw_rd_idx == 0 && !desc_rd_en, "R1 after reset", 80'({hw_rd_idx, desc_rd_en}), 80'(0));

    // single plain descriptor
    add_desc(32'h1000_0000, 8'h12, 8, 16'hA001, 1'b0, 1'b0); post(); wait_idle();
    chk(hw_rd_idx == w_stage, "R10 read index", 80'(hw_rd_idx), 80'(w_stage)); drain();
    // swapped, ragged byte count
    add_desc(32'h2233_4455, 8'h9A, 5, 16'hA002, 1'b1, 1'b0); post(); wait_idle(); drain();
    // gather chain with a zero-length middle entry
    req0 = n_req;
    add_desc(32'h3000_0010, 8'h01, 4, 16'hB001, 1'b0, 1'b1);
    add_desc(32'h3000_0020, 8'h01, 0, 16'hB002, 1'b1, 1'b1);
    add_desc(32'h3000_0030, 8'h02, 12, 16'hB003, 1'b1, 1'b0);
    post(); wait_idle();
    chk(n_req - req0 == 2, "R11 zero length skips request", 80'(n_req - req0), 80'(2));
    drain();
    // open chain must stall until the closing entry is posted
    req0 = n_req; rd0 = hw_rd_idx; wq0 = q_word.size();
    add_desc(32'h4000_0000, 8'h03, 8, 16'hC001, 1'b1, 1'b1);
    add_desc(32'h4000_0100, 8'h03, 4, 16'hC002, 1'b0, 1'b1);
    post(); repeat (40) @(posedge clk);
    chk(n_req == req0, "R8 no request on open chain", 80'(n_req), 80'(req0));
    chk(hw_rd_idx == rd0, "R8 read index held", 80'(hw_rd_idx), 80'(rd0));
    chk(q_word.size() == wq0 + 3, "R8 no output on open chain", 80'(q_word.size()), 80'(wq0 + 3));
    add_desc(32'h4000_0200, 8'h04, 16, 16'hC003, 1'b0, 1'b0); post(); wait_idle();
    chk(hw_rd_idx == 0, "R2 index wrapped to zero", 80'(hw_rd_idx), 80'(0));
    drain();
    // reaps held high across completions
    #2 host_reap = 1'b1;
    add_desc(32'h5000_0000, 8'h05, 4, 16'hD001, 1'b0, 1'b0);
    add_desc(32'h5000_0040, 8'h05, 8, 16'hD002, 1'b1, 1'b1);
    add_desc(32'h5000_0080, 8'h05, 4, 16'hD003, 1'b0, 1'b0);
    add_desc(32'h5000_00C0, 8'h06, 4, 16'hD004, 1'b1, 1'b0);
    post(); wait_idle(); drain();
    // fill the ring to its usable limit
    for (int k = 0; k < DEPTH - 1; k++)
      add_desc(32'h6000_0000 + 32'(k * 16), 8'h07, 4, MW'(16'hE000 + k), k[0], 1'b0);
    post(); @(negedge clk);
    chk(ring_full == 1'b1, "R3 full after depth minus one posts", 80'(ring_full), 80'(1));
    wait_idle();
    chk(done_cnt == IW'(DEPTH - 1), "R9 all completed unreaped", 80'(done_cnt), 80'(DEPTH - 1));
    drain(); @(negedge clk);
    chk(ring_full == 1'b0 && done_cnt == 0, "R3 not full after reap",
        80'({ring_full, done_cnt}), 80'(0));
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R10 actual=hung expected=idle");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule